// File: doc/BRIEF.md
# Encoded-Ratio Controller Clock Divider

This block derives a controller clock from a fast coprocessor clock. Software picks the division ratio with a 3-bit code. The code indexes a fixed, non-linear table of ratios that includes divide-by-6 and divide-by-24. The divided clock has an even duty cycle for every even ratio. With the code for ratio 1, the input clock passes straight through.

A configuration register holds four controls:
- the ratio code,
- an output enable,
- a bypass select, which replaces the divided clock with a clock from an external pin,
- a divider hold.

The ratio code is applied only while the divider is held. A code written while the divider runs is stored and read back, but it does not alter division until the next hold. Releasing the hold starts the counter from zero, so the first output rising edge always falls on the first running cycle. The bypass select and the divider hold are independent, so the counter keeps its phase while the bypass is active.

All configuration fields can be read back, so software can confirm what it programmed. In simulation the output is a level that is high or low per input cycle. For ratio 1 it is a gated copy of the input clock.

Top module: `cdiv_ctl_clkgen`

## Requirements
- R1: The ratio code maps to ratios as follows: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 6, 4 gives 8, 5 gives 16, 6 gives 24, 7 gives 32.
- R2: For every even ratio N, the output is high for N/2 input cycles and then low for N/2 input cycles. On the k-th running edge after release it is high exactly when (k-1) mod N < N/2.
- R3: With ratio 1 (code 0), the output is high while the input clock is high and low while it is low.
- R4: While the divider hold bit is 1:
  - the counter is cleared,
  - the divided output is 0,
  - the ratio code in the register is captured.
  
  On the first edge after the hold clears, the output goes high.
- R5: A ratio code written while the hold bit is 0 has no effect on the output period until the next hold, but it still reads back at once.
- R6: With the bypass bit at 1 and the enable bit at 1, the output equals the external pin clock.
- R7: With the enable bit at 0, the output is 0 whatever the source.
- R8: On each edge where the write strobe is high, the register loads all four fields, and the readback ports show them from that edge on.
- R9: Setting and clearing bypass does not reset or pause the divider. After bypass returns to 0, the output continues the phase it would have had without bypass.
- R10: After the synchronous active-low reset:
  - the ratio code is 0,
  - enable is 0,
  - bypass is 0,
  - the divider hold is 1,
  - the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coprocessor input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Ratio code to write |
| cfg_en | input | 1 | Output enable to write |
| cfg_byp | input | 1 | Bypass select to write (1 = external pin clock) |
| cfg_hold | input | 1 | Divider hold to write (1 = held) |
| ext_clk | input | 1 | External pin clock used in bypass |
| ctl_clk | output | 1 | Controller clock output |
| rb_sel | output | 3 | Readback of stored ratio code |
| rb_en | output | 1 | Readback of enable |
| rb_byp | output | 1 | Readback of bypass select |
| rb_hold | output | 1 | Readback of divider hold |

## Verification
A write lands on the edge where the strobe is high, so readback is sampled one quarter period after that edge. The divider sees a released hold on the next edge, which is running edge k=1. Each divided-output check is made a quarter period after running edge k and compared with the (k-1) mod N formula. For ratio 1, the output follows the input clock without a register, so it is sampled in both the high and the low half of each cycle. Bypass and enable act without a register, so they are checked in the same quarter-period window as the edge that stored them. The bench keeps its own running-edge count through writes and bypass intervals, so phase continuity is predicted rather than read from the design.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the ratio table of the controller clock divider.
// Assumes codes are SEL_W bits wide and every ratio fits in RAT_W bits.
package cdiv_pkg;
    localparam int SEL_W     = 3;
    localparam int NUM_CODES = 1 << SEL_W;
    localparam int MAX_RATIO = 32;
    localparam int RAT_W     = $clog2(MAX_RATIO + 1);

    // Ratio for one code (non-linear table; codes are the software interface).
    function automatic logic [RAT_W-1:0] ratio_of(input int code);
        case (code)
            0:       return RAT_W'(1);
            1:       return RAT_W'(2);
            2:       return RAT_W'(4);
            3:       return RAT_W'(6);
            4:       return RAT_W'(8);
            5:       return RAT_W'(16);
            6:       return RAT_W'(24);
            default: return RAT_W'(32);
        endcase
    endfunction
endpackage

// File: rtl/cdiv_cfg_regs.sv
`timescale 1ns/1ps
// Configuration register with readback.
// Loads all fields on a write strobe. Resets to code 0, disabled, no bypass,
// divider held. Assumes a single writer.
module cdiv_cfg_regs
    import cdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_en,
    input  logic             wr_byp,
    input  logic             wr_hold,
    output logic [SEL_W-1:0] sel_q,
    output logic             en_q,
    output logic             byp_q,
    output logic             hold_q
);
    // Store the programmed fields; hold defaults to 1 so the divider starts idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            en_q   <= 1'b0;
            byp_q  <= 1'b0;
            hold_q <= 1'b1;
        end else if (we) begin
            sel_q  <= wr_sel;
            en_q   <= wr_en;
            byp_q  <= wr_byp;
            hold_q <= wr_hold;
        end
    end

    assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (sel_q == $past(wr_sel)) && (en_q == $past(wr_en))
               && (byp_q == $past(wr_byp)) && (hold_q == $past(wr_hold)));
endmodule

// File: rtl/cdiv_ratio_dec.sv
`timescale 1ns/1ps
// Ratio decoder: maps an applied code to its ratio, the high-phase length and
// a unity flag. The table is built by a generate loop from the package function.
module cdiv_ratio_dec
    import cdiv_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    output logic [RAT_W-1:0] ratio,
    output logic [RAT_W-1:0] hi_len,
    output logic             unity
);
    logic [RAT_W-1:0] table_q [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
        assign table_q[g] = ratio_of(g);
    end

    // Look up the ratio and derive the half period (ratio 1 stays high).
    always_comb begin
        ratio  = table_q[code];
        unity  = (ratio == RAT_W'(1));
        hi_len = unity ? RAT_W'(1) : (ratio >> 1);
    end
endmodule

// File: rtl/cdiv_counter.sv
`timescale 1ns/1ps
// Divider counter.
// While held: clears the count and phase and captures the requested code.
// While running: counts 0..ratio-1 and drives the phase high for the first
// hi_len counts of each period. Assumes ratio and hi_len decode act_sel.
module cdiv_counter
    import cdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel_req,
    input  logic [RAT_W-1:0] ratio,
    input  logic [RAT_W-1:0] hi_len,
    input  logic             unity,
    output logic [SEL_W-1:0] act_sel,
    output logic             phase_q
);
    logic [RAT_W-1:0] cnt_q;
    logic             wrap;

    // Detect the last count of a period.
    always_comb wrap = (cnt_q == ratio - RAT_W'(1));

    // Advance the count, or clear it and capture a new code while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (hold) begin
            act_sel <= sel_req;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            phase_q <= (cnt_q < hi_len);
            cnt_q   <= wrap ? '0 : cnt_q + RAT_W'(1);
        end
    end

    assert_hold_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0) && !phase_q);
    assert_code_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> $stable(act_sel));
    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio);
    assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q) |-> (cnt_q == RAT_W'(1)) || unity);
endmodule

// File: rtl/cdiv_out_mux.sv
`timescale 1ns/1ps
// Output stage.
// For ratio 1 it gates the input clock with the running phase; otherwise it
// passes the registered phase. Bypass selects the external pin clock instead,
// and the enable forces the result low. This is a simulation model, not a
// glitch-free clock multiplexer.
module cdiv_out_mux (
    input  logic clk,
    input  logic phase,
    input  logic unity,
    input  logic byp,
    input  logic en,
    input  logic ext_clk,
    output logic ctl_clk
);
    logic div_lvl;

    // Pick the divided level, then the source, then apply the enable.
    always_comb begin
        div_lvl = unity ? (phase & clk) : phase;
        ctl_clk = en & (byp ? ext_clk : div_lvl);
    end
endmodule

// File: rtl/cdiv_ctl_clkgen.sv
`timescale 1ns/1ps
// Top: encoded-ratio controller clock divider with configuration readback.
// Wires the config register, the counter, the ratio decoder and the output stage.
module cdiv_ctl_clkgen
    import cdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_en,
    input  logic             cfg_byp,
    input  logic             cfg_hold,
    input  logic             ext_clk,
    output logic             ctl_clk,
    output logic [SEL_W-1:0] rb_sel,
    output logic             rb_en,
    output logic             rb_byp,
    output logic             rb_hold
);
    logic [SEL_W-1:0] act_sel;
    logic [RAT_W-1:0] ratio;
    logic [RAT_W-1:0] hi_len;
    logic             unity;
    logic             phase;

    cdiv_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .wr_sel(cfg_sel), .wr_en(cfg_en), .wr_byp(cfg_byp), .wr_hold(cfg_hold),
        .sel_q(rb_sel), .en_q(rb_en), .byp_q(rb_byp), .hold_q(rb_hold)
    );

    cdiv_ratio_dec u_dec (
        .code(act_sel), .ratio(ratio), .hi_len(hi_len), .unity(unity)
    );

    cdiv_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(rb_hold), .sel_req(rb_sel),
        .ratio(ratio), .hi_len(hi_len), .unity(unity),
        .act_sel(act_sel), .phase_q(phase)
    );

    cdiv_out_mux u_out (
        .clk(clk), .phase(phase), .unity(unity), .byp(rb_byp), .en(rb_en),
        .ext_clk(ext_clk), .ctl_clk(ctl_clk)
    );
endmodule

// File: tb/test_cdiv_ctl_clkgen.sv
`timescale 1ns/1ps
module test_cdiv_ctl_clkgen;
    localparam real PERIOD = 5.0;
    localparam int  WD_CYC = 200000;
    // Vector fields: [9] enable, [8:6] code, [5:0] expected ratio (R1).
    localparam logic [9:0] VECS [10] = '{
        {1'b1, 3'd0, 6'd1},  {1'b1, 3'd1, 6'd2},  {1'b1, 3'd2, 6'd4},
        {1'b1, 3'd3, 6'd6},  {1'b1, 3'd4, 6'd8},  {1'b1, 3'd5, 6'd16},
        {1'b1, 3'd6, 6'd24}, {1'b1, 3'd7, 6'd32}, {1'b0, 3'd3, 6'd6},
        {1'b0, 3'd0, 6'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic       cfg_en = 1'b0, cfg_byp = 1'b0, cfg_hold = 1'b1;
    logic       ext_clk = 1'b0;
    logic       ctl_clk;
    logic [2:0] rb_sel;
    logic       rb_en, rb_byp, rb_hold;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    cdiv_ctl_clkgen i_cdiv_ctl_clkgen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_en(cfg_en), .cfg_byp(cfg_byp), .cfg_hold(cfg_hold),
        .ext_clk(ext_clk), .ctl_clk(ctl_clk), .rb_sel(rb_sel), .rb_en(rb_en),
        .rb_byp(rb_byp), .rb_hold(rb_hold)
    );

    always #(PERIOD / 2.0) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Write the register; returns 1 ns after the write edge.
    task automatic wr(input logic [2:0] s, input logic e, input logic b, input logic h);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_en = e; cfg_byp = b; cfg_hold = h;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    // Expected divided level on running edge k for ratio n.
    function automatic int lvl(input int k, input int n);
        return (((k - 1) % n) < (n / 2)) ? 1 : 0;
    endfunction

    // Check the output a quarter period after the next edge (running edge k).
    task automatic sample(input string tag, input int k, input int n, input bit en);
        @(posedge clk);
        #(PERIOD / 4.0);
        if (n == 1) begin
            chk(tag, ctl_clk, en ? 1 : 0);
            #(PERIOD / 2.0);
            chk({tag, " low half"}, ctl_clk, 0);
        end else begin
            chk(tag, ctl_clk, en ? lvl(k, n) : 0);
        end
    endtask

    initial begin
        #(WD_CYC * PERIOD);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1.25;
        // R10: reset state
        chk("R10 sel", rb_sel, 0);
        chk("R10 en", rb_en, 0);
        chk("R10 byp", rb_byp, 0);
        chk("R10 hold", rb_hold, 1);
        chk("R10 out", ctl_clk, 0);

        // R1, R2, R3, R7: walk the ratio table
        foreach (VECS[i]) begin
            logic [9:0] v = VECS[i];
            int n = int'(v[5:0]);
            wr(v[8:6], v[9], 1'b0, 1'b1);
            wr(v[8:6], v[9], 1'b0, 1'b0);
            chk("R8 readback sel", rb_sel, int'(v[8:6]));
            for (int k = 1; k <= 2 * n + 2; k++)
                sample($sformatf("R1/R2/R3/R7 code %0d en %0d k %0d", v[8:6], v[9], k),
                       k, n, v[9]);
        end

        // R4: hold keeps the output low, release gives a high first edge
        wr(3'd2, 1'b1, 1'b0, 1'b1);
        for (int j = 0; j < 4; j++) begin
            @(posedge clk);
            #1.25;
            chk("R4 held low", ctl_clk, 0);
        end
        wr(3'd2, 1'b1, 1'b0, 1'b0);
        for (int k = 1; k <= 4; k++) sample($sformatf("R4 first edges k %0d", k), k, 4, 1'b1);

        // R5: code written while running is ignored (ratio stays 4); R8 readback
        wr(3'd7, 1'b1, 1'b0, 1'b0);  // write edge is running edge 5
        chk("R5 readback new code", rb_sel, 7);
        for (int k = 6; k <= 13; k++) sample($sformatf("R5 ratio kept k %0d", k), k, 4, 1'b1);

        // R6, R9: bypass to the pin clock, then return with the phase kept
        wr(3'd7, 1'b1, 1'b1, 1'b0);  // running edge 14
        chk("R8 readback byp", rb_byp, 1);
        #(PERIOD / 4.0 - 1.0);
        chk("R6 pin low", ctl_clk, 0);
        for (int k = 15; k <= 18; k++) begin
            @(negedge clk);
            ext_clk = k[0];
            @(posedge clk);
            #1.25;
            chk($sformatf("R6 pin follow k %0d", k), ctl_clk, k % 2);
        end
        wr(3'd7, 1'b1, 1'b0, 1'b0);  // running edge 19
        for (int k = 20; k <= 27; k++) sample($sformatf("R9 phase kept k %0d", k), k, 4, 1'b1);

        // R7: enable 0 blocks the bypass source too
        wr(3'd7, 1'b0, 1'b1, 1'b0);
        ext_clk = 1'b1;
        #1;
        chk("R7 disabled bypass", ctl_clk, 0);

        // R5: the new code applies after the next hold (code 7, ratio 32)
        wr(3'd7, 1'b1, 1'b0, 1'b1);
        wr(3'd7, 1'b1, 1'b0, 1'b0);
        for (int k = 1; k <= 34; k++) sample($sformatf("R5 new code after hold k %0d", k), k, 32, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule